// File: doc/BRIEF.md
# Master Clock Source Selector

This block picks the internal master clock from two candidates: a clock recovered by a PLL and a clock from an external oscillator. A 2-bit mode value and a force-lock bit are written through a small write port. A PLL unlock status input, brought into the control clock domain, steers the choice in the automatic modes. The block outputs the registered source decision, the selected clock from a glitch-free multiplexer, and a flag that says whether timing derived from the selected clock can be trusted.

Two modes are manual: one always names the PLL and one always names the oscillator. Two modes are automatic. One follows the lock state. The other keeps whatever source is active while the PLL stays locked and falls back to the oscillator on unlock. In the PLL-manual mode a loss of lock puts the oscillator on the output clock, but the source decision stays on the PLL and the timing flag drops. Setting force-lock removes that fallback.

Top module: `mcs_top`

## Requirements
- R1: While and after reset, `src_sel` is 0 (PLL), `timing_valid` is 1, `cfg_err` is 0, the stored mode is 00 and force-lock is clear, so `clk_out` carries `pll_clk`.
- R2: Mode 00 sets `src_sel` to 0 (PLL) whatever the unlock status.
- R3: Mode 01 sets `src_sel` to 1 (oscillator) whatever the unlock status.
- R4: Mode 10 keeps the present `src_sel` while the PLL is locked and sets it to 1 (oscillator) while the PLL is unlocked.
- R5: Mode 11 sets `src_sel` to 0 while the PLL is locked and to 1 while it is unlocked.
- R6: In mode 00 without force-lock, an unlocked PLL puts `osc_clk` on `clk_out` and drives `timing_valid` low, while `src_sel` stays 0.
- R7: With force-lock set and the PLL unlocked, `clk_out` keeps carrying `pll_clk` and `timing_valid` is low.
- R8: A write with `wr_force` = 1 and a nonzero `wr_mode` stores mode 00 with force-lock set and sets `cfg_err`. `cfg_err` stays set through later writes until reset.
- R9: The clock multiplexer never enables both inputs at once. After a change of selection has settled, `clk_out` carries the selected clock.
- R10: `pll_unlock` passes through two control-clock flops before use, so a change shows on `src_sel` at the third rising `clk` edge after it and not before.
- R11: `timing_valid` is 1 whenever `src_sel` is 1 (oscillator).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset, used in all three clock domains |
| pll_clk | input | 1 | PLL-recovered clock candidate |
| osc_clk | input | 1 | External oscillator clock candidate |
| pll_unlock | input | 1 | Asynchronous PLL unlock status, 1 = unlocked |
| wr_en | input | 1 | Configuration write strobe |
| wr_mode | input | 2 | Mode value: 00 PLL manual, 01 oscillator manual, 10 hold, 11 automatic |
| wr_force | input | 1 | Force-lock value to write |
| src_sel | output | 1 | Registered source decision, 0 = PLL, 1 = oscillator |
| clk_out | output | 1 | Glitch-free selected master clock |
| timing_valid | output | 1 | 1 when timing derived from the selected clock is valid |
| cfg_err | output | 1 | Sticky flag for a force-lock write with a nonzero mode |

## Verification
The enable exclusivity check in the multiplexer assumes the request into it does not reverse before a handover has finished. The stimulus therefore changes only one thing that moves the request at a time, and waits many oscillator periods before the next change. The control checks assume `pll_unlock` is the only asynchronous input. The bench drives writes and status changes one nanosecond after a control edge and reads results one nanosecond after a later edge. The output clock is identified by counting its edges over a fixed window: the two candidate clocks have clearly different periods.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    typedef enum logic [1:0] {
        MODE_PLL  = 2'b00,
        MODE_OSC  = 2'b01,
        MODE_HOLD = 2'b10,
        MODE_AUTO = 2'b11
    } src_mode_e;

    typedef enum logic {
        SRC_PLL = 1'b0,
        SRC_OSC = 1'b1
    } src_e;

    typedef struct packed {
        logic      force_lock;
        src_mode_e mode;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{force_lock: 1'b0, mode: MODE_PLL};

    // Source decision for one control cycle.
    function automatic src_e pick_source(input src_mode_e m, input logic unl, input src_e cur);
        unique case (m)
            MODE_PLL:  return SRC_PLL;
            MODE_OSC:  return SRC_OSC;
            MODE_HOLD: return unl ? SRC_OSC : cur;
            default:   return unl ? SRC_OSC : SRC_PLL;
        endcase
    endfunction

endpackage

// File: rtl/mcs_sync.sv
module mcs_sync #(
    parameter int STAGES  = 2,
    parameter bit ON_FALL = 1'b0,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (ON_FALL) begin : g_fall
            always_ff @(negedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end else begin : g_rise
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mcs_clk_mux.sv
module mcs_clk_mux #(
    parameter int STAGES = 2
) (
    input  logic rst,
    input  logic pll_clk,
    input  logic osc_clk,
    input  logic sel_osc,
    output logic clk_out
);
    logic pll_en, osc_en;
    logic pll_req, osc_req;

    // Each side may only request once the other side's final enable is off.
    assign pll_req = !sel_osc && !osc_en;
    assign osc_req =  sel_osc && !pll_en;

    // Enables move on falling edges, while their own clock is low.
    mcs_sync #(.STAGES(STAGES), .ON_FALL(1'b1), .RST_VAL(1'b0)) u_pll_en (
        .clk(pll_clk), .rst(rst), .d(pll_req), .q(pll_en)
    );
    mcs_sync #(.STAGES(STAGES), .ON_FALL(1'b1), .RST_VAL(1'b0)) u_osc_en (
        .clk(osc_clk), .rst(rst), .d(osc_req), .q(osc_en)
    );

    assign clk_out = (pll_clk & pll_en) | (osc_clk & osc_en);

    // R9: the two gated paths are never open together.
    a_r9_one_enable_osc: assert property (@(posedge osc_clk) disable iff (rst)
        !(pll_en && osc_en));
    a_r9_one_enable_pll: assert property (@(posedge pll_clk) disable iff (rst)
        !(pll_en && osc_en));
endmodule

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
    import mcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pll_unlock,
    input  logic       wr_en,
    input  logic [1:0] wr_mode,
    input  logic       wr_force,
    output src_e       src_q,
    output logic       mux_osc_q,
    output logic       valid_q,
    output logic       err_q
);
    cfg_t cfg_q;
    logic unlock_s;
    src_e src_next;

    mcs_sync #(.STAGES(SYNC_STAGES), .ON_FALL(1'b0), .RST_VAL(1'b0)) u_unlock_sync (
        .clk(clk), .rst(rst), .d(pll_unlock), .q(unlock_s)
    );

    // Configuration store; force-lock pins the mode to PLL-manual.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
            err_q <= 1'b0;
        end else if (wr_en) begin
            cfg_q.force_lock <= wr_force;
            cfg_q.mode       <= wr_force ? MODE_PLL : src_mode_e'(wr_mode);
            if (wr_force && (wr_mode != 2'b00)) err_q <= 1'b1;
        end
    end

    assign src_next = pick_source(cfg_q.mode, unlock_s, src_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q     <= SRC_PLL;
            mux_osc_q <= 1'b0;
            valid_q   <= 1'b1;
        end else begin
            src_q     <= src_next;
            mux_osc_q <= (src_next == SRC_OSC) || (unlock_s && !cfg_q.force_lock);
            valid_q   <= !((src_next == SRC_PLL) && unlock_s);
        end
    end

    a_r2_manual_pll: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MODE_PLL) |=> (src_q == SRC_PLL));
    a_r3_manual_osc: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MODE_OSC) |=> (src_q == SRC_OSC));
    a_r4_hold_keeps: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MODE_HOLD && !unlock_s) |=> (src_q == $past(src_q)));
    a_r4_hold_fallback: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MODE_HOLD && unlock_s) |=> (src_q == SRC_OSC));
    a_r5_auto_unlock: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MODE_AUTO && unlock_s) |=> (src_q == SRC_OSC));
    a_r6_fallback_invalid: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MODE_PLL && !cfg_q.force_lock && unlock_s) |=> (mux_osc_q && !valid_q));
    a_r7_forced_stays_pll: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.force_lock && unlock_s) |=> (!mux_osc_q && !valid_q));
    a_r8_err_sets: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_force && wr_mode != 2'b00) |=> (err_q && cfg_q.mode == MODE_PLL));
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
    a_r11_osc_valid: assert property (@(posedge clk) disable iff (rst)
        (src_q == SRC_OSC) |-> valid_q);
endmodule

// File: rtl/mcs_top.sv
module mcs_top
    import mcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MUX_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pll_clk,
    input  logic       osc_clk,
    input  logic       pll_unlock,
    input  logic       wr_en,
    input  logic [1:0] wr_mode,
    input  logic       wr_force,
    output logic       src_sel,
    output logic       clk_out,
    output logic       timing_valid,
    output logic       cfg_err
);
    src_e src_q;
    logic mux_osc;

    mcs_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
        .clk(clk), .rst(rst), .pll_unlock(pll_unlock),
        .wr_en(wr_en), .wr_mode(wr_mode), .wr_force(wr_force),
        .src_q(src_q), .mux_osc_q(mux_osc), .valid_q(timing_valid), .err_q(cfg_err)
    );

    mcs_clk_mux #(.STAGES(MUX_STAGES)) u_mux (
        .rst(rst), .pll_clk(pll_clk), .osc_clk(osc_clk),
        .sel_osc(mux_osc), .clk_out(clk_out)
    );

    assign src_sel = src_q;
endmodule

// File: tb/tb_mcs_top.sv
module tb_mcs_top;
    logic clk = 1'b0, pll_clk = 1'b0, osc_clk = 1'b0;
    logic rst = 1'b1, pll_unlock = 1'b0, wr_en = 1'b0, wr_force = 1'b0;
    logic [1:0] wr_mode = 2'b00;
    logic src_sel, clk_out, timing_valid, cfg_err;

    int n_chk = 0, n_fail = 0, edge_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;       // 250 MHz control clock
    always #3 pll_clk = ~pll_clk; // 6 ns
    always #5 osc_clk = ~osc_clk; // 10 ns

    always @(posedge clk_out) edge_cnt++;

    mcs_top dut (
        .clk(clk), .rst(rst), .pll_clk(pll_clk), .osc_clk(osc_clk),
        .pll_unlock(pll_unlock), .wr_en(wr_en), .wr_mode(wr_mode), .wr_force(wr_force),
        .src_sel(src_sel), .clk_out(clk_out), .timing_valid(timing_valid), .cfg_err(cfg_err)
    );

    // {force, mode[1:0], unlock, exp_src, exp_valid, exp_osc_on_clk_out, 0}
    localparam int NV = 13;
    localparam logic [7:0] VEC [NV] = '{
        8'b0_00_0_0_1_0_0, // R2 PLL manual, locked
        8'b0_00_1_0_0_1_0, // R6 PLL manual, unlocked: oscillator on clock, invalid
        8'b0_01_1_1_1_1_0, // R3 oscillator manual, unlocked
        8'b0_01_0_1_1_1_0, // R3 oscillator manual, locked
        8'b0_11_0_0_1_0_0, // R5 automatic, locked
        8'b0_11_1_1_1_1_0, // R5 automatic, unlocked
        8'b0_10_1_1_1_1_0, // R4 hold, unlocked
        8'b0_10_0_1_1_1_0, // R4 hold, relocked: keeps oscillator
        8'b0_00_0_0_1_0_0, // R2 back to PLL
        8'b0_10_0_0_1_0_0, // R4 hold, locked: keeps PLL
        8'b1_00_1_0_0_0_0, // R7 force-lock, unlocked: PLL stays
        8'b0_01_0_1_1_1_0, // R3 leave force-lock
        8'b0_00_0_0_1_0_0  // R2 PLL again
    };
    localparam int VREQ [NV] = '{2, 6, 3, 3, 5, 5, 4, 4, 2, 4, 7, 3, 2};

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic f, input logic [1:0] m);
        wr_en = 1'b1; wr_force = f; wr_mode = m;
        tick(1);
        wr_en = 1'b0;
    endtask

    // 0 = pll_clk, 1 = osc_clk, 2 = neither; 150 control cycles = 600 ns
    task automatic which_clock(output int cls);
        int c0;
        c0 = edge_cnt;
        tick(150);
        c0 = edge_cnt - c0;
        if (c0 >= 95 && c0 <= 105)     cls = 0;
        else if (c0 >= 55 && c0 <= 65) cls = 1;
        else                           cls = 2;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int cls;
        tick(20);
        // R1 during reset
        check("R1 src in reset", src_sel, 0);
        check("R1 valid in reset", timing_valid, 1);
        check("R1 err in reset", cfg_err, 0);
        rst = 1'b0;
        tick(40);
        which_clock(cls);
        check("R1 clock after reset", cls, 0);
        check("R1 src after reset", src_sel, 0);

        // Vector table walk (R2..R7, R9, R11)
        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("R%0d vec%0d", VREQ[i], i);
            pll_unlock = VEC[i][4];
            do_write(VEC[i][7], VEC[i][6:5]);
            tick(40);
            check({tg, " src"}, src_sel, int'(VEC[i][3]));
            check({tg, " valid"}, timing_valid, int'(VEC[i][2]));
            which_clock(cls);
            check({tg, " R9 clk"}, cls, int'(VEC[i][1]));
        end

        // R10 latency: automatic mode, locked, then unlock
        do_write(1'b0, 2'b11);
        tick(40);
        pll_unlock = 1'b1;
        tick(2);
        check("R10 src before third edge", src_sel, 0);
        tick(1);
        check("R10 src at third edge", src_sel, 1);
        check("R11 valid on oscillator", timing_valid, 1);
        pll_unlock = 1'b0;
        tick(3);
        check("R10 src relock", src_sel, 0);
        do_write(1'b0, 2'b00);
        tick(40);

        // R8 force-lock with nonzero mode
        check("R8 err clear before", cfg_err, 0);
        do_write(1'b1, 2'b11);
        check("R8 err set", cfg_err, 1);
        pll_unlock = 1'b1;          // mode 11 would pick oscillator; stored mode is 00
        tick(40);
        check("R8 src stays PLL", src_sel, 0);
        which_clock(cls);
        check("R8 forced clock", cls, 0);
        do_write(1'b0, 2'b01);
        tick(40);
        check("R8 err sticky", cfg_err, 1);
        check("R8 src after clean write", src_sel, 1);
        pll_unlock = 1'b0;
        rst = 1'b1;
        tick(20);
        check("R8 R1 err cleared by reset", cfg_err, 0);
        rst = 1'b0;
        tick(40);
        which_clock(cls);
        check("R1 clock after second reset", cls, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule